// File: doc/BRIEF.md
# Byte Serial Channel with Handshake

This block is one byte-wide synchronous serial channel. A single 8-bit control and status register sets its role and reports its state, and an 8-bit buffer holds the byte. The buffer is loaded by the core, shifted out on the data pin, or filled from it. As master, the channel makes its own serial clock by toggling the clock pin on each tick of an external rate generator. As slave, it follows a clock that arrives on the clock pin. In either role it can transmit or receive. Bytes move most significant bit first. A transmitter changes the data line after a falling clock edge, and a receiver samples it on the rising edge. The clock idles high.

Each transfer is gated by a single-byte enable. This enable clears itself after the byte unless the auto re-enable bit keeps it set. A toggle bit can swap the transmit/receive role once the byte ends. With handshaking on, both clock lines act as open-drain. A slave whose buffer is not ready pulls the shared clock low. A master waits for the wired clock to read high before it begins a byte. The pins are modelled as separate input, output and output-enable signals, and both pin inputs pass through a synchronizer.

Control register bits, from bit 7 down to bit 0: master select, transmit select, toggle, handshake, single-byte enable, auto re-enable, overrun/underrun flag, buffer status.

Top module: `ssc_channel`

## Requirements
- R1: After reset the control register reads 00h. With that value the clock pin output-enable and the data pin output-enable are both low.
- R2: As master transmitter (bit 7 = 1, bit 6 = 1), with bit 3 set and bit 0 clear, the channel starts a byte. It toggles the clock pin on each baud tick, 8 low/high periods per byte, and the clock idles high. The data pin carries the buffer MSB first and is stable while the clock is high.
- R3: A receiver (bit 6 = 0) shifts the data pin into the buffer MSB first on each rising clock edge. As master it uses its own clock, and as slave it uses the clock pin. The 8-bit result is readable on the buffer output after the byte.
- R4: Buffer status (bit 0) goes to 1 at the end of every byte. A core buffer write outside a transfer clears it in transmit mode, and a core buffer read outside a transfer clears it in receive mode. A byte starts only while bit 0 is 0.
- R5: Single-byte enable (bit 3) clears at the end of a byte when auto re-enable (bit 2) is 0. When bit 2 is 1, bit 3 stays set and the next byte starts as soon as bit 0 returns to 0.
- R6: With the toggle bit (bit 5) set, bit 6 inverts and bit 5 clears at the end of the byte.
- R7: A core buffer write or read during a byte sets the overrun/underrun flag (bit 1). The write is ignored, and the byte in flight is sent unchanged.
- R8: A slave clocked by the master while not ready (bit 3 = 0 or bit 0 = 1) sets bit 1, and its buffer is unchanged.
- R9: In handshake mode (bit 4 = 1), a slave that is idle and not ready drives the clock pin low (output-enable 1, output 0). It releases the pin once it is ready.
- R10: In handshake mode a master does not start a byte while the clock pin reads low. It starts after the line goes high.
- R11: A register write of 0 to bit 1 or bit 0 clears that bit, and a write of 1 leaves it unchanged. Bits 7 to 2 take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudTick | input | 1 | One-cycle tick from the rate generator; each tick is a half serial clock period |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write value |
| regRdData | output | 8 | Control register contents |
| bufWrEn | input | 1 | Core buffer write strobe |
| bufWrData | input | 8 | Core buffer write value |
| bufRdEn | input | 1 | Core buffer read strobe |
| bufRdData | output | 8 | Buffer contents |
| clkPinIn | input | 1 | Level seen on the serial clock pin |
| clkPinOut | output | 1 | Value driven on the serial clock pin |
| clkPinOe | output | 1 | Output-enable of the serial clock pin |
| datPinIn | input | 1 | Level seen on the serial data pin |
| datPinOut | output | 1 | Value driven on the serial data pin |
| datPinOe | output | 1 | Output-enable of the serial data pin |

## Verification
Internal state shows up at the ports quickly. A bit counter that is off by one gives the wrong number of clock periods, so the master's byte ends early or late. This is seen as a wrong byte in the scoreboard, and as buffer status rising before or after the eighth rising edge, within one baud tick. If the end-of-byte update to the control bits is wrong, the register reads back a wrong value on the next read after the byte. It may also start, or fail to start, a second byte, which shows within one tick as clock edges that should not be there, or as edges that are missing. If the slave ready/hold logic is wrong, the wired clock line is held low or released at the wrong time, or a spurious overrun flag appears. Either is visible two synchronizer cycles after the edge that caused it.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int REG_W = 8;
  localparam int B_MS  = 7;
  localparam int B_TR  = 6;
  localparam int B_TGL = 5;
  localparam int B_HS  = 4;
  localparam int B_STE = 3;
  localparam int B_ATR = 2;
  localparam int B_OUF = 1;
  localparam int B_TBS = 0;

  typedef struct packed {
    logic loadBuf;
    logic shiftOut;
    logic shiftIn;
  } sscStrobe_t;
endpackage

// File: rtl/ssc_dpath.sv
module ssc_dpath import ssc_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  sscStrobe_t        strobe,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic              clkPinIn,
  input  logic              datPinIn,
  output logic              clkSync,
  output logic [DATA_W-1:0] bufQ,
  output logic              datOut
);
  logic [SYNC_STAGES-1:0] clkPipe;
  logic [SYNC_STAGES-1:0] datPipe;
  logic datSync;

  // pin synchronizers; clock line idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe <= '1;
      datPipe <= '0;
    end else begin
      clkPipe[0] <= clkPinIn;
      datPipe[0] <= datPinIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        clkPipe[i] <= clkPipe[i-1];
        datPipe[i] <= datPipe[i-1];
      end
    end
  end

  assign clkSync = clkPipe[SYNC_STAGES-1];
  assign datSync = datPipe[SYNC_STAGES-1];

  // the buffer doubles as the shift register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufQ <= '0;
    end else if (strobe.loadBuf) begin
      bufQ <= bufWrData;
    end else if (strobe.shiftOut) begin
      bufQ <= {bufQ[DATA_W-2:0], 1'b0};
    end else if (strobe.shiftIn) begin
      bufQ <= {bufQ[DATA_W-2:0], datSync};
    end
  end

  assign datOut = bufQ[DATA_W-1];
endmodule

// File: rtl/ssc_ctrl.sv
module ssc_ctrl import ssc_pkg::*; #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudTick,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             bufWrEn,
  input  logic             bufRdEn,
  input  logic             clkSync,
  output logic [REG_W-1:0] ctrlQ,
  output sscStrobe_t       strobe,
  output logic             xferBusy,
  output logic             clkOut,
  output logic             clkOe,
  output logic             datOe
);
  logic ms, tr, tgl, hs, ste, atr, ouf, tbs;
  logic mClk, clkPrev;
  logic [CNT_W-1:0] bitCnt;

  logic ready, slvFall, slvRise, slvHold, slvStart, slvMiss;
  logic mStart, mFall, mRise, edgeFall, edgeRise, lastRise, coreHit;

  assign ready    = ste & ~tbs;
  assign slvFall  = ~ms & clkPrev & ~clkSync;
  assign slvRise  = ~ms & ~clkPrev & clkSync;
  assign slvHold  = ~ms & hs & ~ready & ~xferBusy;
  assign slvStart = slvFall & ~xferBusy & ready;
  assign slvMiss  = slvFall & ~xferBusy & ~ready & ~slvHold;
  assign mStart   = ms & ~xferBusy & ready & (~hs | clkSync);
  assign mFall    = ms & xferBusy & baudTick & mClk;
  assign mRise    = ms & xferBusy & baudTick & ~mClk;
  assign edgeFall = mFall | (slvFall & xferBusy);
  assign edgeRise = mRise | (slvRise & xferBusy);
  assign lastRise = edgeRise && (bitCnt == CNT_W'(DATA_W - 1));
  assign coreHit  = xferBusy & (bufWrEn | bufRdEn);

  always_comb begin
    strobe          = '0;
    strobe.loadBuf  = bufWrEn & ~xferBusy;
    strobe.shiftOut = tr & edgeFall & (bitCnt != '0);
    strobe.shiftIn  = ~tr & edgeRise;
  end

  // transfer sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferBusy <= 1'b0;
      bitCnt   <= '0;
      mClk     <= 1'b1;
      clkPrev  <= 1'b1;
    end else begin
      clkPrev <= clkSync;
      if (mStart || slvStart) begin
        xferBusy <= 1'b1;
        bitCnt   <= '0;
      end else if (lastRise) begin
        xferBusy <= 1'b0;
      end
      if (edgeRise) bitCnt <= bitCnt + 1'b1;
      if (mFall) mClk <= 1'b0;
      else if (mRise) mClk <= 1'b1;
      else if (!ms) mClk <= 1'b1;
    end
  end

  // control and status bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {ms, tr, tgl, hs, ste, atr, ouf, tbs} <= '0;
    end else if (regWrEn) begin
      ms  <= regWrData[B_MS];
      tr  <= regWrData[B_TR];
      tgl <= regWrData[B_TGL];
      hs  <= regWrData[B_HS];
      ste <= regWrData[B_STE];
      atr <= regWrData[B_ATR];
      ouf <= ouf & regWrData[B_OUF];
      tbs <= tbs & regWrData[B_TBS];
    end else begin
      if (coreHit || slvMiss) ouf <= 1'b1;
      if (lastRise) begin
        tbs <= 1'b1;
        if (!atr) ste <= 1'b0;
        if (tgl) begin
          tr  <= ~tr;
          tgl <= 1'b0;
        end
      end else if ((bufWrEn && tr && !xferBusy) || (bufRdEn && !tr && !xferBusy)) begin
        tbs <= 1'b0;
      end
    end
  end

  always_comb begin
    ctrlQ        = '0;
    ctrlQ[B_MS]  = ms;
    ctrlQ[B_TR]  = tr;
    ctrlQ[B_TGL] = tgl;
    ctrlQ[B_HS]  = hs;
    ctrlQ[B_STE] = ste;
    ctrlQ[B_ATR] = atr;
    ctrlQ[B_OUF] = ouf;
    ctrlQ[B_TBS] = tbs;
  end

  // master drives push-pull, or open-drain low phases when handshaking
  assign clkOut = ms & mClk;
  assign clkOe  = ms ? (~hs | ~mClk) : slvHold;
  assign datOe  = tr;
endmodule

// File: rtl/ssc_channel.sv
module ssc_channel import ssc_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              bufWrEn,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic              bufRdEn,
  output logic [DATA_W-1:0] bufRdData,
  input  logic              clkPinIn,
  output logic              clkPinOut,
  output logic              clkPinOe,
  input  logic              datPinIn,
  output logic              datPinOut,
  output logic              datPinOe
);
  sscStrobe_t strobe;
  logic clkSync;
  logic xferBusy;

  ssc_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .baudTick(baudTick),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .bufWrEn(bufWrEn), .bufRdEn(bufRdEn), .clkSync(clkSync),
    .ctrlQ(regRdData), .strobe(strobe), .xferBusy(xferBusy),
    .clkOut(clkPinOut), .clkOe(clkPinOe), .datOe(datPinOe)
  );

  ssc_dpath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bufWrData(bufWrData),
    .clkPinIn(clkPinIn), .datPinIn(datPinIn), .clkSync(clkSync),
    .bufQ(bufRdData), .datOut(datPinOut)
  );
endmodule

// File: rtl/ssc_chk.sv
module ssc_chk (
  input logic       clk,
  input logic       rstN,
  input logic       baudTick,
  input logic       regWrEn,
  input logic [7:0] regRdData,
  input logic       clkPinOut,
  input logic       clkPinOe,
  input logic       datPinOut,
  input logic       xferBusy
);
  AST_CLK_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[7] && $past(regRdData[7]) && !$stable(clkPinOut) |-> $past(baudTick)); // R2

  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    xferBusy && $past(xferBusy) && regRdData[7] && regRdData[6] && clkPinOut && $past(clkPinOut)
    |-> $stable(datPinOut)); // R2

  AST_SLAVE_HOLD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    clkPinOe && !regRdData[7] |-> !clkPinOut); // R9

  AST_OUF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(regRdData[1]) && !$past(regWrEn) |-> regRdData[1]); // R11

  AST_TGL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(xferBusy) && $past(regRdData[5]) && !$past(regWrEn) |-> !regRdData[5]); // R6

  AST_TBS_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(xferBusy) && !$past(regWrEn) |-> regRdData[0]); // R4
endmodule

bind ssc_channel ssc_chk chk_i (
  .clk(clk), .rstN(rstN), .baudTick(baudTick), .regWrEn(regWrEn),
  .regRdData(regRdData), .clkPinOut(clkPinOut), .clkPinOe(clkPinOe),
  .datPinOut(datPinOut), .xferBusy(xferBusy)
);

// File: tb/ssc_channel_tb_top.sv
`timescale 1ns/1ps
module ssc_channel_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baudTick = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic bufWrEn = 1'b0;
  logic [7:0] bufWrData = '0;
  logic bufRdEn = 1'b0;
  logic [7:0] bufRdData;
  logic clkPinOut, clkPinOe, datPinOut, datPinOe;
  logic benchClk = 1'b1;
  logic benchDat = 1'b0;
  logic clkLine, datLine;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int riseCount = 0;
  logic [7:0] expQ[$];

  always #2.5 clk = ~clk;

  // wired lines: low if anyone pulls low, else pulled up
  assign clkLine = ~((clkPinOe & ~clkPinOut) | ~benchClk);
  assign datLine = datPinOe ? datPinOut : benchDat;

  ssc_channel dut_i (
    .clk(clk), .rstN(rstN), .baudTick(baudTick),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .bufWrEn(bufWrEn), .bufWrData(bufWrData), .bufRdEn(bufRdEn), .bufRdData(bufRdData),
    .clkPinIn(clkLine), .clkPinOut(clkPinOut), .clkPinOe(clkPinOe),
    .datPinIn(datLine), .datPinOut(datPinOut), .datPinOe(datPinOe)
  );

  // baud tick: one pulse every 4 cycles
  int tickDiv = 0;
  always @(negedge clk) begin
    tickDiv <= (tickDiv + 1) % 4;
    baudTick <= (tickDiv == 3);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: collect bits at rising edges of the clock line while a byte is expected
  logic prevLine = 1'b1;
  logic [7:0] monByte = '0;
  int monBits = 0;
  always @(negedge clk) begin
    if (!prevLine && clkLine) begin
      riseCount++;
      if (expQ.size() != 0) begin
        monByte = {monByte[6:0], datLine};
        monBits++;
        if (monBits == 8) begin
          logic [7:0] e;
          e = expQ.pop_front();
          chk(monByte == e, "R2 serial byte", monByte, e);
          monBits = 0;
        end
      end
    end
    prevLine = clkLine;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] v);
    @(negedge clk); regWrEn = 1'b1; regWrData = v;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic wrBuf(input logic [7:0] v);
    @(negedge clk); bufWrEn = 1'b1; bufWrData = v;
    @(negedge clk); bufWrEn = 1'b0;
  endtask

  task automatic rdBuf();
    @(negedge clk); bufRdEn = 1'b1;
    @(negedge clk); bufRdEn = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    expQ.push_back(v);
  endtask

  task automatic waitDone();
    int n = 0;
    while (!regRdData[0] && n < 400) begin @(negedge clk); n++; end
    idle(2);
  endtask

  // bench acts as master: 8 clock periods, data changed while clock is low
  task automatic benchMaster(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); benchClk = 1'b0; benchDat = v[i];
      idle(8);
      benchClk = 1'b1;
      idle(8);
    end
    idle(6);
  endtask

  // bench acts as slave transmitter for the master receiver
  task automatic feedBits(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic p;
      p = clkLine;
      @(negedge clk);
      while (!(p && !clkLine)) begin p = clkLine; @(negedge clk); end
      benchDat = v[i];
    end
  endtask

  initial begin
    int rc;
    idle(3);
    rstN = 1'b1;
    idle(2);
    // R1 reset state
    chk(regRdData == 8'h00, "R1 reset reg", regRdData, 8'h00);
    chk(clkPinOe == 1'b0, "R1 clk oe idle", clkPinOe, 0);
    chk(datPinOe == 1'b0, "R1 dat oe idle", datPinOe, 0);

    // R2 master transmit
    wrReg(8'hC0);
    idle(1);
    chk(clkPinOe && clkPinOut, "R2 clock idles high", {clkPinOe, clkPinOut}, 3);
    wrBuf(8'hA5);
    sendByte(8'hA5);
    wrReg(8'hC8);
    waitDone();
    chk(regRdData == 8'hC1, "R5 R4 ste clears tbs sets", regRdData, 8'hC1);

    // R6 toggle after transfer
    wrBuf(8'h3C);
    chk(regRdData == 8'hC0, "R4 tx write clears tbs", regRdData, 8'hC0);
    sendByte(8'h3C);
    wrReg(8'hE8);
    waitDone();
    chk(regRdData == 8'h81, "R6 toggled to receiver", regRdData, 8'h81);
    chk(datPinOe == 1'b0, "R6 data released", datPinOe, 0);

    // R3 master receive
    wrReg(8'h88);
    feedBits(8'h5A);
    waitDone();
    chk(bufRdData == 8'h5A, "R3 master rx byte", bufRdData, 8'h5A);
    chk(regRdData == 8'h81, "R4 rx full", regRdData, 8'h81);
    rdBuf();
    chk(regRdData == 8'h80, "R4 rx read clears tbs", regRdData, 8'h80);

    // R5 auto re-enable
    wrBuf(8'h11);
    sendByte(8'h11);
    wrReg(8'hCC);
    waitDone();
    chk(regRdData == 8'hCD, "R5 ste kept with atr", regRdData, 8'hCD);
    rc = riseCount;
    idle(40);
    chk(riseCount == rc, "R4 no start while tbs set", riseCount, rc);
    sendByte(8'h22);
    wrBuf(8'h22);
    idle(20);
    wrBuf(8'h99); // R7 write during byte
    waitDone();
    chk(regRdData == 8'hCF, "R7 ouf set mid transfer", regRdData, 8'hCF);
    chk(expQ.size() == 0, "R5 second byte sent", expQ.size(), 0);
    wrReg(8'hCD);
    chk(regRdData == 8'hCD, "R11 write zero clears ouf only", regRdData, 8'hCD);
    wrReg(8'hC0);
    chk(regRdData == 8'hC0, "R11 write zero clears tbs", regRdData, 8'hC0);

    // R3 slave receive
    wrReg(8'h08);
    benchMaster(8'hC3);
    chk(bufRdData == 8'hC3, "R3 slave rx byte", bufRdData, 8'hC3);
    chk(regRdData == 8'h01, "R5 slave ste clears", regRdData, 8'h01);

    // R8 slave clocked while not ready
    benchMaster(8'h0F);
    chk(regRdData == 8'h03, "R8 ouf on unready slave", regRdData, 8'h03);
    chk(bufRdData == 8'hC3, "R8 buffer unchanged", bufRdData, 8'hC3);

    // R9 handshake slave hold
    wrReg(8'h1C);
    chk(regRdData == 8'h1C && clkPinOe == 1'b0, "R9 ready slave releases", {regRdData, clkPinOe}, {8'h1C, 1'b0});
    benchMaster(8'h96);
    chk(bufRdData == 8'h96, "R3 handshake slave byte", bufRdData, 8'h96);
    chk(regRdData == 8'h1D, "R9 no spurious ouf", regRdData, 8'h1D);
    chk(clkPinOe && !clkPinOut, "R9 slave holds clock low", {clkPinOe, clkPinOut}, 2);
    rdBuf();
    idle(1);
    chk(!clkPinOe, "R9 slave released", clkPinOe, 0);

    // R10 master waits for line high
    wrBuf(8'h77);
    wrReg(8'hD4);
    @(negedge clk); benchClk = 1'b0;
    idle(4);
    wrReg(8'hDC);
    idle(40);
    chk(regRdData == 8'hDC, "R10 master waits", regRdData, 8'hDC);
    chk(!clkPinOe, "R10 master not driving", clkPinOe, 0);
    @(negedge clk); benchClk = 1'b1;
    idle(2);
    sendByte(8'h77);
    waitDone();
    chk(regRdData == 8'hDD, "R10 byte done after release", regRdData, 8'hDD);
    chk(expQ.size() == 0, "R10 byte sent", expQ.size(), 0);

    idle(10);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule